// File: doc/BRIEF.md
# Video Memory Write Queue with Aging Latency

This block is a four-deep write queue that sits between a host data port and three video memories. The host offers writes over a valid/ready handshake. Each write carries a target code, a 17-bit address and a 16-bit word. Every accepted write becomes a queue entry. The entry holds two byte-pending flags and a small age counter, and the counter is loaded with 2 on entry.

A `tick` strobe ages every occupied entry. When the memory side grants a slot through `slot_en`, the head entry writes into the memory its target selects. The write port is combinational from the head entry, so it is valid in the same cycle as the grant.

VRAM entries in normal mode take two slots: the low byte goes first and the high byte later. All other entries finish in one slot. After an entry completes, the queue shifts down by one position. At each shift, a pending fill transfer receives its fill word through a one-cycle strobe. That word comes from the head entry when the head targets VRAM, and from the entry behind the head in every other case.

Back-pressure on the host side is simple. `in_ready` is high exactly when fewer than four entries are occupied. A write offered while the queue is full waits, with its fields held, until it is accepted. It is never lost.

Top module: `vwq_top`

## Requirements
- R1: A synchronous active-high `rst` clears every entry. During and after reset `empty`=1, `full`=0, `in_ready`=1, `wr_en`=0 and `fill_load`=0.
- R2: `in_ready` = 1 exactly when fewer than 4 entries are occupied. A write is accepted on a rising edge where `in_valid` and `in_ready` are both 1. A held write is accepted later, in its turn, and is not dropped.
- R3: A newly accepted entry has age 2, and the tick in the cycle it is accepted does not age it. On each rising edge with `tick`=1, every occupied entry whose age is above zero loses 1. The head may write only while its age is 0 and `slot_en`=1.
- R4: An entry with target code 1 (VRAM) while `vram_word_mode`=0 writes in two slots. The first slot has `wr_byte_en`=2'b01 and leaves the entry at the head. The second slot has `wr_byte_en`=2'b10 and removes the entry.
- R5: An entry with any other target code, or any entry while `vram_word_mode`=1, writes in one slot with `wr_byte_en`=2'b11 and is removed.
- R6: While `dma_active`=1 and `dma_preload_busy`=1, `wr_en` stays 0 and the queue does not shift.
- R7: `fill_load` is 1 exactly in a cycle where the head is removed while `cmd_pending`=1 and `dma_mode`=2'd2. In that cycle, `fill_word` is the head data if the head target is 1. Otherwise it is the data of the second entry, or 0 when no second entry exists.
- R8: `empty` is 1 when no entry has a pending byte. `full` is 1 when all four entries are occupied.
- R9: Entries write in acceptance order. `wr_target`, `wr_addr` and `wr_data` show the head entry's fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Host write offered |
| in_ready | output | 1 | Queue can accept a write |
| in_target | input | 4 | Target code of the offered write |
| in_addr | input | 17 | Address of the offered write |
| in_data | input | 16 | Data of the offered write |
| tick | input | 1 | Aging strobe |
| slot_en | input | 1 | Memory access slot granted this cycle |
| vram_word_mode | input | 1 | 1: VRAM entries write in one slot |
| dma_active | input | 1 | A DMA transfer is running |
| dma_preload_busy | input | 1 | DMA preload count is nonzero |
| cmd_pending | input | 1 | A command is pending |
| dma_mode | input | 2 | DMA mode, 2 = fill |
| wr_en | output | 1 | Memory write this cycle |
| wr_target | output | 4 | Target code of the write |
| wr_addr | output | 17 | Write address |
| wr_data | output | 16 | Write word |
| wr_byte_en | output | 2 | Byte enables, bit 0 = low byte |
| full | output | 1 | All entries occupied |
| empty | output | 1 | No entry occupied |
| fill_load | output | 1 | Fill word delivered this cycle |
| fill_word | output | 16 | Fill word |

## Verification
The bench aims at five cases. The first is exact aging: an entry that retires one tick early or one tick late shows up as a `wr_en` mismatch in the first slot after it is accepted. The second is the two-slot VRAM sequence: a design that writes the high byte first, or shifts after the low byte, gives a wrong byte enable or skips an entry. The third is the fill-word source: a design that reads the wrong slot, or loses the zero that an empty second slot must supply, gives a wrong `fill_word`. The fourth and fifth are a full queue and preload stalls: a design that drops held writes breaks acceptance order, and one that writes during a preload stall raises `wr_en` when it must stay 0.

// File: rtl/vwq_pkg.sv
package vwq_pkg;
  localparam int TGT_W  = 4;
  localparam int ADDR_W = 17;
  localparam int DATA_W = 16;
  localparam int AGE_W  = 2;
  localparam logic [AGE_W-1:0] AGE_START = AGE_W'(2);
  localparam logic [TGT_W-1:0] TGT_VRAM  = TGT_W'(1);
  localparam logic [1:0]       MODE_FILL = 2'd2;

  typedef struct packed {
    logic [TGT_W-1:0]  tgt;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic              hi_pend;
    logic              lo_pend;
    logic [AGE_W-1:0]  age;
  } entry_t;
endpackage

// File: rtl/vwq_store.sv
module vwq_store
  import vwq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [TGT_W-1:0]  push_tgt,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data,
  input  logic              advance,
  input  logic              clr_lower,
  input  logic              tick,
  output entry_t            head,
  output entry_t            second,
  output logic              full,
  output logic              empty
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  entry_t q   [DEPTH];
  entry_t sh  [DEPTH];
  entry_t nq  [DEPTH];
  logic [DEPTH-1:0] occ;
  logic [CNT_W-1:0] cnt, cnt_post;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < DEPTH; i++) cnt = cnt + CNT_W'(occ[i]);
  end
  assign cnt_post = cnt - CNT_W'(advance);

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    assign occ[gi] = q[gi].hi_pend | q[gi].lo_pend;
    if (gi == DEPTH - 1) begin : g_last
      assign sh[gi] = '0;
    end else begin : g_mid
      assign sh[gi] = q[gi+1];
    end

    always_comb begin
      entry_t e;
      e = advance ? sh[gi] : q[gi];
      if (clr_lower && gi == 0) e.lo_pend = 1'b0;
      if (tick && (e.hi_pend | e.lo_pend) && e.age != '0) e.age = e.age - 1'b1;
      if (push && cnt_post == CNT_W'(gi))
        e = '{tgt: push_tgt, addr: push_addr, data: push_data,
              hi_pend: 1'b1, lo_pend: 1'b1, age: AGE_START};
      nq[gi] = e;
    end

    always_ff @(posedge clk) begin
      if (rst) q[gi] <= '0;
      else     q[gi] <= nq[gi];
    end
  end

  assign head   = q[0];
  assign second = q[1];
  assign full   = (cnt == CNT_W'(DEPTH));
  assign empty  = (cnt == '0);

  // R2: the queue never accepts a write with no free entry
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);

  // R4: after the low byte the same entry stays at the head with only the high byte pending
  assert_low_then_high_R4: assert property (@(posedge clk) disable iff (rst)
    clr_lower |=> (q[0].hi_pend && !q[0].lo_pend && q[0].addr == $past(q[0].addr)));

  // R9: a shift moves the second entry to the head unchanged
  assert_shift_order_R9: assert property (@(posedge clk) disable iff (rst)
    (advance && occ[1]) |=> (q[0].addr == $past(q[1].addr) && q[0].data == $past(q[1].data)));

  // R8: flags never both set
  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));
endmodule

// File: rtl/vwq_retire.sv
module vwq_retire
  import vwq_pkg::*;
(
  input  entry_t      head,
  input  logic        slot_en,
  input  logic        vram_word_mode,
  input  logic        dma_active,
  input  logic        dma_preload_busy,
  output logic        wr_en,
  output logic [1:0]  wr_byte_en,
  output logic        clr_lower,
  output logic        advance
);
  logic occupied, aged, blocked, split;

  assign occupied = head.hi_pend | head.lo_pend;
  assign aged     = (head.age == '0);
  assign blocked  = dma_active & dma_preload_busy;
  assign split    = (head.tgt == TGT_VRAM) & ~vram_word_mode;

  assign wr_en      = occupied & aged & slot_en & ~blocked;
  assign wr_byte_en = split ? (head.lo_pend ? 2'b01 : 2'b10) : 2'b11;
  assign clr_lower  = wr_en & split & head.lo_pend;
  assign advance    = wr_en & ~(split & head.lo_pend);
endmodule

// File: rtl/vwq_fill.sv
module vwq_fill
  import vwq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  entry_t            head,
  input  entry_t            second,
  input  logic              advance,
  input  logic              cmd_pending,
  input  logic [1:0]        dma_mode,
  output logic              fill_load,
  output logic [DATA_W-1:0] fill_word
);
  assign fill_load = advance & cmd_pending & (dma_mode == MODE_FILL);
  assign fill_word = (head.tgt == TGT_VRAM) ? head.data : second.data;

  // R7: a fill word is only delivered when a pending fill is present
  assert_fill_gate_R7: assert property (@(posedge clk) disable iff (rst)
    fill_load |-> (cmd_pending && dma_mode == MODE_FILL));
endmodule

// File: rtl/vwq_top.sv
module vwq_top
  import vwq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [TGT_W-1:0]  in_target,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic              tick,
  input  logic              slot_en,
  input  logic              vram_word_mode,
  input  logic              dma_active,
  input  logic              dma_preload_busy,
  input  logic              cmd_pending,
  input  logic [1:0]        dma_mode,
  output logic              wr_en,
  output logic [TGT_W-1:0]  wr_target,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [1:0]        wr_byte_en,
  output logic              full,
  output logic              empty,
  output logic              fill_load,
  output logic [DATA_W-1:0] fill_word
);
  entry_t head, second;
  logic   push, advance, clr_lower;

  assign in_ready = ~full;
  assign push     = in_valid & in_ready;

  vwq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .push(push),
    .push_tgt(in_target), .push_addr(in_addr), .push_data(in_data),
    .advance(advance), .clr_lower(clr_lower), .tick(tick),
    .head(head), .second(second), .full(full), .empty(empty)
  );

  vwq_retire u_retire (
    .head(head), .slot_en(slot_en), .vram_word_mode(vram_word_mode),
    .dma_active(dma_active), .dma_preload_busy(dma_preload_busy),
    .wr_en(wr_en), .wr_byte_en(wr_byte_en),
    .clr_lower(clr_lower), .advance(advance)
  );

  vwq_fill u_fill (
    .clk(clk), .rst(rst), .head(head), .second(second), .advance(advance),
    .cmd_pending(cmd_pending), .dma_mode(dma_mode),
    .fill_load(fill_load), .fill_word(fill_word)
  );

  assign wr_target = head.tgt;
  assign wr_addr   = head.addr;
  assign wr_data   = head.data;

  // R3: the store's head age and the retire decision agree
  assert_age_gate_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (head.age == '0));

  // R6: no write while the DMA preload holds the queue
  assert_preload_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (dma_active && dma_preload_busy) |-> !wr_en);

  // R1: nothing is written or delivered with an empty queue
  assert_idle_empty_R1: assert property (@(posedge clk) disable iff (rst)
    empty |-> (!wr_en && !fill_load));
endmodule

// File: tb/vwq_top_bench.sv
module vwq_top_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst, in_valid, in_ready, tick, slot_en, vram_word_mode;
  logic        dma_active, dma_preload_busy, cmd_pending;
  logic [1:0]  dma_mode, wr_byte_en;
  logic [3:0]  in_target, wr_target;
  logic [16:0] in_addr, wr_addr;
  logic [15:0] in_data, wr_data, fill_word;
  logic        wr_en, full, empty, fill_load;

  vwq_top u_vwq_top (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_target(in_target), .in_addr(in_addr), .in_data(in_data),
    .tick(tick), .slot_en(slot_en), .vram_word_mode(vram_word_mode),
    .dma_active(dma_active), .dma_preload_busy(dma_preload_busy),
    .cmd_pending(cmd_pending), .dma_mode(dma_mode),
    .wr_en(wr_en), .wr_target(wr_target), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_byte_en(wr_byte_en), .full(full), .empty(empty),
    .fill_load(fill_load), .fill_word(fill_word)
  );

  typedef struct {
    int tgt; int addr; int data; bit hi; bit lo; int age;
  } ment_t;
  ment_t mq[$];

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic drive_idle();
    in_valid = 0; in_target = 0; in_addr = 0; in_data = 0;
    tick = 0; slot_en = 1; vram_word_mode = 0;
    dma_active = 0; dma_preload_busy = 0; cmd_pending = 0; dma_mode = 0;
  endtask

  // compare outputs against the model, then advance the model by one edge
  task automatic step_model();
    bit e_ready, e_wr, e_adv, e_clr, e_fill;
    int e_be, e_fw;
    e_ready = (mq.size() < 4);
    e_wr = 0; e_adv = 0; e_clr = 0; e_be = 3; e_fill = 0; e_fw = 0;
    if (mq.size() > 0 && mq[0].age == 0 && slot_en && !(dma_active && dma_preload_busy)) begin
      e_wr = 1;
      if (mq[0].tgt == 1 && !vram_word_mode) begin
        if (mq[0].lo) begin e_be = 1; e_clr = 1; end
        else begin e_be = 2; e_adv = 1; end
      end else e_adv = 1;
    end
    if (e_adv && cmd_pending && dma_mode == 2) begin
      e_fill = 1;
      e_fw = (mq[0].tgt == 1) ? mq[0].data : ((mq.size() > 1) ? mq[1].data : 0);
    end

    chk(in_ready == e_ready, "R2", "in_ready", in_ready, e_ready);
    chk(full == (mq.size() == 4), "R8", "full", full, mq.size() == 4);
    chk(empty == (mq.size() == 0), "R8", "empty", empty, mq.size() == 0);
    chk(wr_en == e_wr, "R3 R6", "wr_en", wr_en, e_wr);
    if (e_wr && wr_en) begin
      chk(int'(wr_byte_en) == e_be, "R4 R5", "wr_byte_en", wr_byte_en, e_be);
      chk(int'(wr_addr) == mq[0].addr && int'(wr_data) == mq[0].data
          && int'(wr_target) == mq[0].tgt, "R9", "wr_addr", wr_addr, mq[0].addr);
    end
    chk(fill_load == e_fill, "R7", "fill_load", fill_load, e_fill);
    if (e_fill && fill_load)
      chk(int'(fill_word) == e_fw, "R7", "fill_word", fill_word, e_fw);

    if (e_clr) mq[0].lo = 0;
    if (e_adv) void'(mq.pop_front());
    if (tick) foreach (mq[i]) if (mq[i].age > 0) mq[i].age--;
    if (in_valid && e_ready)
      mq.push_back('{tgt: int'(in_target), addr: int'(in_addr), data: int'(in_data),
                     hi: 1, lo: 1, age: 2});
  endtask

  task automatic new_host_word(input int vram_pct);
    int r;
    r = $urandom_range(99);
    in_target = (r < vram_pct) ? 4'd1 : 4'($urandom_range(5));
    in_addr   = 17'($urandom);
    in_data   = 16'($urandom);
  endtask

  // phase: 0 free flowing, 1 slow memory, 2 preload stalls and fills
  task automatic run_phase(input int cycles, input int phase);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (!in_valid || in_ready_seen) begin
        in_valid = ($urandom_range(99) < (phase == 1 ? 80 : 50));
        new_host_word(phase == 2 ? 30 : 60);
      end
      tick    = (phase == 0) ? 1'b1 : 1'($urandom_range(1));
      slot_en = ($urandom_range(99) < (phase == 1 ? 25 : 70));
      if (c % 150 == 0) vram_word_mode = ($urandom_range(3) == 0);
      dma_active       = (phase == 2) ? 1'($urandom_range(1)) : 1'b0;
      dma_preload_busy = (phase == 2) ? ($urandom_range(2) == 0) : 1'b0;
      cmd_pending      = 1'($urandom_range(1));
      dma_mode         = (phase == 2) ? 2'd2 : 2'($urandom_range(3));
      #1;
      in_ready_seen = in_valid && in_ready;
      step_model();
    end
  endtask

  bit in_ready_seen = 0;

  initial begin
    drive_idle();
    rst = 1;
    // R1: reset state observed while reset is held, with a slot offered
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(empty == 1 && full == 0, "R1", "empty/full", {full, empty}, 1);
      chk(in_ready == 1 && wr_en == 0 && fill_load == 0, "R1", "ready/wr",
          {in_ready, wr_en, fill_load}, 4);
    end
    @(negedge clk); rst = 0;

    // R3: single VRAM entry with tick each cycle; R4 low then high byte
    @(negedge clk);
    in_valid = 1; in_target = 4'd1; in_addr = 17'h1abcd; in_data = 16'hbeef; tick = 1;
    #1; step_model();
    @(negedge clk); in_valid = 0; #1; step_model();
    chk(wr_en == 0, "R3", "wr_en age1", wr_en, 0);
    @(negedge clk); #1; step_model();
    chk(wr_en == 0, "R3", "wr_en age0 edge pending", wr_en, 0);
    @(negedge clk); #1;
    chk(wr_en == 1 && wr_byte_en == 2'b01, "R4", "low byte", wr_byte_en, 1);
    step_model();
    @(negedge clk); #1;
    chk(wr_en == 1 && wr_byte_en == 2'b10, "R4", "high byte", wr_byte_en, 2);
    step_model();
    @(negedge clk); #1;
    chk(empty == 1, "R4", "empty after high byte", empty, 1);
    step_model();

    // R7: fill word from second slot (non-VRAM head), and zero when alone
    @(negedge clk);
    slot_en = 0; in_valid = 1; in_target = 4'd3; in_addr = 17'h10; in_data = 16'h1111;
    #1; step_model();
    @(negedge clk); in_target = 4'd5; in_addr = 17'h20; in_data = 16'h2222; #1; step_model();
    @(negedge clk); in_valid = 0; #1; step_model();
    @(negedge clk); #1; step_model();
    @(negedge clk); slot_en = 1; cmd_pending = 1; dma_mode = 2'd2; #1;
    chk(fill_load == 1 && fill_word == 16'h2222, "R7", "fill from second", fill_word, 16'h2222);
    step_model();
    @(negedge clk); #1;
    chk(fill_load == 1 && fill_word == 16'h0000, "R7", "fill zero second", fill_word, 0);
    step_model();

    // R6: preload stall holds a ready head
    @(negedge clk); in_valid = 1; in_target = 4'd3; slot_en = 0; #1; step_model();
    @(negedge clk); in_valid = 0; #1; step_model();
    @(negedge clk); #1; step_model();
    @(negedge clk); slot_en = 1; dma_active = 1; dma_preload_busy = 1; #1;
    chk(wr_en == 0, "R6", "stalled by preload", wr_en, 0);
    step_model();
    @(negedge clk); dma_preload_busy = 0; #1;
    chk(wr_en == 1 && wr_byte_en == 2'b11, "R5", "single access", wr_byte_en, 3);
    step_model();
    drive_idle();

    in_ready_seen = 0;
    run_phase(3000, 0);
    run_phase(3000, 1);
    run_phase(3000, 2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule